// File: doc/BRIEF.md
# Mailbox Bridge to Serial-Controller Core Registers

This block puts one 64-bit command word on the host side and uses it to reach the small 8-bit register set of a serial-bus controller core. Software does not address the core registers directly. It writes a command word that carries a launch flag, a direction flag, a primary opcode, a secondary opcode and a data byte. The bridge carries out the access a fixed number of cycles later and then drops the launch flag. Software polls the same word until that flag reads back as zero. On a read, it then finds the result in the low byte.

Targets are picked in two levels. The primary opcode either selects the clock-high-period register directly, or defers to the secondary opcode. The secondary opcode selects the data, control, clock-divider, status or core-reset register. The clock-divider register and the status register share one secondary code: writes with that code go to the divider and reads with that code come from the status register. The core registers are modelled as storage. The clock-high, clock-divider and control bytes drive outputs toward the protocol engine, which lies outside this block.

Top module: `csr_core_bridge`

## Requirements
- R1: After reset the command word reads all zeros. The clock-high register holds 0x18, the status register holds 0xF8, and the data, control and clock-divider registers hold 0x00.
- R2: A host write whose bit 63 is 1 launches an access. Bit 63 then reads 1 for exactly LATENCY cycles (default 2) after the write edge, and then clears.
- R3: While bit 63 reads 1, any host write is ignored. The command word and the access in flight are unchanged.
- R4: Primary opcode 4 (bits 60:57) addresses the clock-high register for both write and read. Bit 56 = 1 means read and 0 means write. A write takes bits 7:0 of the word.
- R5: Primary opcode 6 defers to the secondary opcode in bits 34:32. Code 1 addresses the data register and code 2 addresses the control register, for both write and read.
- R6: Secondary code 3 writes the clock-divider register, which is visible on eng_clk_div. A read with code 3 returns the status register and never the divider value.
- R7: A write with secondary code 7 returns the core to idle. Data, control and clock-divider become 0x00 and status reads 0xF8. The clock-high register keeps its value.
- R8: Any other primary or secondary code completes normally after LATENCY cycles. A read with such a code returns 0x00, and a write with such a code changes no core register.
- R9: On completion only bit 63 is cleared, and a read also replaces bits 7:0 with the result. Every other bit keeps the value the host wrote.
- R10: A host write with bit 63 = 0, made while idle, is stored as written and launches no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wr_data | input | 64 | Command word written by the host |
| host_rd_data | output | 64 | Current command word as seen by the host |
| eng_clk_high | output | 8 | Clock-high-period register toward the engine |
| eng_clk_div | output | 8 | Clock-divider register toward the engine |
| eng_ctrl | output | 8 | Control register toward the engine |

## Verification
The assertions assume that the host strobes a write for one cycle at a time and never drives the strobe while reset is active. They also assume that a launch is followed by at least LATENCY cycles before the flag is sampled again. The stimulus meets these assumptions by driving each write for a single cycle between falling edges. It injects a second write on purpose only while the flag is high, to exercise the ignore rule. The scoreboard waits for each queued completion before it issues the next access, except in that one injected case.

// File: rtl/csr_core_bridge_pkg.sv
package csr_core_bridge_pkg;
  localparam int WORD_W    = 64;
  localparam int BYTE_W    = 8;
  localparam int VLD_BIT   = 63;
  localparam int DIR_BIT   = 56;
  localparam int OP_LSB    = 57;
  localparam int OP_W      = 4;
  localparam int SUB_LSB   = 32;
  localparam int SUB_W     = 3;

  localparam logic [OP_W-1:0]  OP_CLK_HIGH = 4'd4;
  localparam logic [OP_W-1:0]  OP_DEFER    = 4'd6;
  localparam logic [SUB_W-1:0] SUB_DATA    = 3'd1;
  localparam logic [SUB_W-1:0] SUB_CTRL    = 3'd2;
  localparam logic [SUB_W-1:0] SUB_DIV_ST  = 3'd3;
  localparam logic [SUB_W-1:0] SUB_RESET   = 3'd7;

  localparam logic [BYTE_W-1:0] STATUS_IDLE = 8'hF8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CLK_HIGH,
    TGT_DATA,
    TGT_CTRL,
    TGT_CLK_DIV,
    TGT_STATUS,
    TGT_RESET
  } target_e;
endpackage

// File: rtl/bridge_rst_sync.sv
module bridge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
  import csr_core_bridge_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [SUB_W-1:0] sub_op,
  input  logic             is_read,
  output target_e          target
);
  always_comb begin
    target = TGT_NONE;
    if (op == OP_CLK_HIGH) begin
      target = TGT_CLK_HIGH;
    end else if (op == OP_DEFER) begin
      case (sub_op)
        SUB_DATA:   target = TGT_DATA;
        SUB_CTRL:   target = TGT_CTRL;
        SUB_DIV_ST: target = is_read ? TGT_STATUS : TGT_CLK_DIV;
        SUB_RESET:  target = TGT_RESET;
        default:    target = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_launch_timer.sv
module bridge_launch_timer #(
  parameter int LATENCY = 2,
  localparam int CNT_W = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (launch) begin
      cnt_d  = CNT_W'(LATENCY);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/bridge_core_regs.sv
module bridge_core_regs
  import csr_core_bridge_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CLK_HIGH_INIT = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_rd,
  input  target_e           target,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] clk_high,
  output logic [BYTE_W-1:0] clk_div,
  output logic [BYTE_W-1:0] ctrl
);
  logic [BYTE_W-1:0] high_q, high_d, div_q, div_d, ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] data_q, data_d, stat_q, stat_d;
  logic              wr_en;

  assign wr_en = acc_en && !acc_rd;

  always_comb begin
    high_d = high_q;
    div_d  = div_q;
    ctrl_d = ctrl_q;
    data_d = data_q;
    stat_d = stat_q;
    case (target)
      TGT_CLK_HIGH: high_d = wdata;
      TGT_CLK_DIV:  div_d  = wdata;
      TGT_CTRL:     ctrl_d = wdata;
      TGT_DATA:     data_d = wdata;
      TGT_RESET: begin
        div_d  = '0;
        ctrl_d = '0;
        data_d = '0;
        stat_d = STATUS_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q <= CLK_HIGH_INIT;
      div_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
      stat_q <= STATUS_IDLE;
    end else if (wr_en) begin
      high_q <= high_d;
      div_q  <= div_d;
      ctrl_q <= ctrl_d;
      data_q <= data_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (target)
      TGT_CLK_HIGH: rdata = high_q;
      TGT_DATA:     rdata = data_q;
      TGT_CTRL:     rdata = ctrl_q;
      TGT_STATUS:   rdata = stat_q;
      default:      rdata = '0;
    endcase
  end

  assign clk_high = high_q;
  assign clk_div  = div_q;
  assign ctrl     = ctrl_q;
endmodule

// File: rtl/csr_core_bridge.sv
module csr_core_bridge
  import csr_core_bridge_pkg::*;
#(
  parameter int                LATENCY       = 2,
  parameter int                RST_STAGES    = 2,
  parameter logic [BYTE_W-1:0] CLK_HIGH_INIT = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wr_data,
  output logic [WORD_W-1:0] host_rd_data,
  output logic [BYTE_W-1:0] eng_clk_high,
  output logic [BYTE_W-1:0] eng_clk_div,
  output logic [BYTE_W-1:0] eng_ctrl
);
  logic              rst_n_sync;
  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic              cmd_en, wr_accept, launch, acc_done;
  target_e           target;
  logic [BYTE_W-1:0] rd_byte;

  bridge_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  assign wr_accept = host_wr_en && !cmd_q[VLD_BIT];
  assign launch    = wr_accept && host_wr_data[VLD_BIT];

  bridge_launch_timer #(.LATENCY(LATENCY)) u_timer (
    .clk(clk), .rst_n(rst_n_sync), .launch(launch), .done(acc_done)
  );

  bridge_cmd_decode u_dec (
    .op     (cmd_q[OP_LSB +: OP_W]),
    .sub_op (cmd_q[SUB_LSB +: SUB_W]),
    .is_read(cmd_q[DIR_BIT]),
    .target (target)
  );

  bridge_core_regs #(.CLK_HIGH_INIT(CLK_HIGH_INIT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .acc_en  (acc_done),
    .acc_rd  (cmd_q[DIR_BIT]),
    .target  (target),
    .wdata   (cmd_q[BYTE_W-1:0]),
    .rdata   (rd_byte),
    .clk_high(eng_clk_high),
    .clk_div (eng_clk_div),
    .ctrl    (eng_ctrl)
  );

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    if (wr_accept) begin
      cmd_d  = host_wr_data;
      cmd_en = 1'b1;
    end else if (acc_done) begin
      cmd_d[VLD_BIT] = 1'b0;
      if (cmd_q[DIR_BIT]) cmd_d[BYTE_W-1:0] = rd_byte;
      cmd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  cmd_q <= '0;
    else if (cmd_en)  cmd_q <= cmd_d;
  end

  assign host_rd_data = cmd_q;
endmodule

// File: rtl/csr_core_bridge_chk.sv
module csr_core_bridge_chk #(
  parameter int LATENCY = 2,
  localparam int AGE_W = $clog2(LATENCY + 2)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr_en,
  input logic [63:0] host_wr_data,
  input logic [63:0] word,
  input logic        done
);
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age_q <= '0;
    else if (word[63]) age_q <= age_q + AGE_W'(1);
    else              age_q <= '0;
  end

  AST_VALID_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    word[63] |-> (age_q < AGE_W'(LATENCY))); // R2

  AST_VALID_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word[63]) |-> ($past(age_q) == AGE_W'(LATENCY - 1))); // R2

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (word[63] && host_wr_en && !done) |=> $stable(word)); // R3

  AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word[63]) |-> (word[62:8] == $past(word[62:8]))); // R9

  AST_IDLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!word[63] && host_wr_en) |=> (word == $past(host_wr_data))); // R10
endmodule

bind csr_core_bridge csr_core_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .host_wr_en  (host_wr_en),
  .host_wr_data(host_wr_data),
  .word        (host_rd_data),
  .done        (acc_done)
);

// File: tb/tb_csr_core_bridge.sv
module tb_csr_core_bridge;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [63:0] host_wr_data = '0;
  logic [63:0] host_rd_data;
  logic [7:0]  eng_clk_high, eng_clk_div, eng_ctrl;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  csr_core_bridge #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data),
    .eng_clk_high(eng_clk_high), .eng_clk_div(eng_clk_div), .eng_ctrl(eng_ctrl)
  );

  task automatic check_eq(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit rd, input logic [3:0] op,
                                     input logic [2:0] sub, input logic [7:0] b);
    logic [63:0] w;
    w = 64'h0000_A500_0000_0000;
    w[63] = 1'b1;
    w[56] = rd;
    w[60:57] = op;
    w[34:32] = sub;
    w[7:0] = b;
    return w;
  endfunction

  // Monitor: pops expected completions as the flag falls, checks word and span (R2, R9)
  bit prev_v = 1'b0;
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_rd_data[63]) hi_cnt++;
      else if (prev_v) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2: unexpected completion actual %h expected none", host_rd_data);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check_eq(host_rd_data, e, {"R9 ", t});
          check_eq(64'(hi_cnt), 64'(LAT), {"R2 span ", t});
        end
        hi_cnt = 0;
      end
      prev_v = host_rd_data[63];
    end
  end

  // Driver: launches one access, queues its expected completed word
  task automatic launch(input logic [63:0] w, input logic [7:0] rbyte,
                        input string tag, input bit inject_busy);
    logic [63:0] e;
    e = w;
    e[63] = 1'b0;
    if (w[56]) e[7:0] = rbyte;
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    host_wr_en = 1'b1;
    host_wr_data = w;
    @(negedge clk);
    if (inject_busy) begin
      host_wr_data = mk(1'b0, 4'd6, 3'd1, 8'h22);
      @(negedge clk);
    end
    host_wr_en = 1'b0;
    host_wr_data = '0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_eq(host_rd_data, 64'h0, "R1 word");
    check_eq({56'h0, eng_clk_high}, 64'h18, "R1 clk_high");
    check_eq({56'h0, eng_clk_div}, 64'h0, "R1 clk_div");
    check_eq({56'h0, eng_ctrl}, 64'h0, "R1 ctrl");

    // R4 clock-high register
    launch(mk(1, 4'd4, 3'd0, 8'h00), 8'h18, "R4 read reset value", 0);
    launch(mk(0, 4'd4, 3'd0, 8'h3C), 8'h00, "R4 write", 0);
    launch(mk(1, 4'd4, 3'd0, 8'hEE), 8'h3C, "R4 readback", 0);
    check_eq({56'h0, eng_clk_high}, 64'h3C, "R4 port");

    // R5 data and control
    launch(mk(0, 4'd6, 3'd1, 8'h5A), 8'h00, "R5 data write", 0);
    launch(mk(1, 4'd6, 3'd1, 8'h00), 8'h5A, "R5 data read", 0);
    launch(mk(0, 4'd6, 3'd2, 8'h44), 8'h00, "R5 ctrl write", 0);
    launch(mk(1, 4'd6, 3'd2, 8'h00), 8'h44, "R5 ctrl read", 0);
    check_eq({56'h0, eng_ctrl}, 64'h44, "R5 ctrl port");

    // R6 shared code
    launch(mk(0, 4'd6, 3'd3, 8'h99), 8'h00, "R6 div write", 0);
    check_eq({56'h0, eng_clk_div}, 64'h99, "R6 div port");
    launch(mk(1, 4'd6, 3'd3, 8'h00), 8'hF8, "R6 status read", 0);

    // R8 unused codes
    launch(mk(1, 4'd0, 3'd1, 8'h00), 8'h00, "R8 op0 read", 0);
    launch(mk(1, 4'd6, 3'd5, 8'h00), 8'h00, "R8 sub5 read", 0);
    launch(mk(1, 4'd15, 3'd2, 8'h00), 8'h00, "R8 op15 read", 0);
    launch(mk(0, 4'd2, 3'd1, 8'h77), 8'h00, "R8 unused write", 0);
    launch(mk(0, 4'd6, 3'd4, 8'h77), 8'h00, "R8 unused sub write", 0);
    launch(mk(1, 4'd6, 3'd1, 8'h00), 8'h5A, "R8 data untouched", 0);
    check_eq({40'h0, eng_clk_high, eng_clk_div, eng_ctrl}, 64'h3C9944, "R8 ports untouched");

    // R3 write while busy is ignored
    launch(mk(0, 4'd6, 3'd1, 8'h11), 8'h00, "R3 launch with busy write", 1);
    launch(mk(1, 4'd6, 3'd1, 8'h00), 8'h11, "R3 data holds first value", 0);

    // R10 write with flag clear is stored, no access
    @(negedge clk);
    host_wr_en = 1'b1;
    host_wr_data = 64'h0C00_0001_0000_00AB;
    @(negedge clk);
    host_wr_en = 1'b0;
    host_wr_data = '0;
    check_eq(host_rd_data, 64'h0C00_0001_0000_00AB, "R10 stored word");
    repeat (LAT + 1) @(negedge clk);
    check_eq(host_rd_data, 64'h0C00_0001_0000_00AB, "R10 no access");
    launch(mk(1, 4'd6, 3'd1, 8'h00), 8'h11, "R10 data unchanged", 0);

    // R7 core reset
    launch(mk(0, 4'd6, 3'd7, 8'h00), 8'h00, "R7 reset write", 0);
    launch(mk(1, 4'd6, 3'd1, 8'h00), 8'h00, "R7 data cleared", 0);
    launch(mk(1, 4'd6, 3'd2, 8'h00), 8'h00, "R7 ctrl cleared", 0);
    launch(mk(1, 4'd6, 3'd3, 8'h00), 8'hF8, "R7 status idle", 0);
    launch(mk(1, 4'd4, 3'd0, 8'h00), 8'h3C, "R7 clk_high kept", 0);
    check_eq({48'h0, eng_clk_div, eng_ctrl}, 64'h0, "R7 ports cleared");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule